// File: doc/BRIEF.md
# SDRAM Burst Column Address Sequencer

This block produces the column address for every beat of one SDRAM burst. A burst is started by a single-cycle start strobe that carries a start column, a burst-length code and an ordering choice. From the next cycle on, the block presents one column per clock with a valid strobe, and it flags the final beat of a fixed-length burst. It fits inside a memory model or a memory controller wherever the column counter of a read or write burst is needed.

Two orderings are supported. In sequential order the low bits of the column count upward and wrap inside the aligned block whose size is the burst length, while the upper bits hold. In interleaved order each beat's low bits are the start low bits exclusive-ORed with the beat index. A sequential full-page mode walks the whole column space, wraps from the top column to zero and runs until it is stopped or replaced. A burst can be cut short on any cycle by a stop strobe, or replaced on any cycle by a new start. The combination of full page and interleaved order is not legal; it runs as a sequential full-page burst and raises an error flag.

Top module: `sdram_col_seq`

## Requirements
- R1: After reset, colValid, lastBeat and cfgErr are 0 and colOut is 0.
- R2: A start sampled high on a rising edge makes colValid 1 and colOut equal to startCol from that edge on; lenCode and interleaveIn are captured at that edge, and changes to them during the burst have no effect on it.
- R3: lenCode selects the burst length: 3'b000 gives 1 beat, 3'b001 gives 2, 3'b010 gives 4, 3'b011 gives 8, and any code with bit 2 set gives full page (2**COL_W columns, 512 by default). A fixed-length burst shows exactly that many valid beats, then colValid returns to 0.
- R4: With interleaveIn 0, beat i shows the start column with its low log2(BL) bits replaced by (start low bits + i) modulo BL; the upper bits stay equal to those of the start column.
- R5: With interleaveIn 1 and a fixed length, beat i shows the start column with its low log2(BL) bits exclusive-ORed with i.
- R6: A full-page burst counts upward by one per beat, wraps from the highest column to 0, and continues until a stop or a new start.
- R7: lastBeat is 1 exactly on beat BL-1 of a fixed-length burst and is never 1 in a full-page burst or while colValid is 0.
- R8: A stop sampled high while a burst is running and start is low ends the burst: from that edge colValid is 0. A stop while idle has no effect.
- R9: A start sampled during a running burst replaces it at once (start wins over stop): the next beat shows the new startCol as beat 0 of the new burst with the new settings.
- R10: A start with full-page length and interleaveIn 1 runs a sequential full-page burst and sets cfgErr from that edge; cfgErr stays 1 until a start with a legal setting clears it.
- R11: Whenever colValid is 0, colOut is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a new burst (also replaces a running one) |
| stop | input | 1 | End the running burst |
| startCol | input | COL_W | Start column of the new burst |
| lenCode | input | 3 | Burst-length code, see R3 |
| interleaveIn | input | 1 | 0 sequential order, 1 interleaved order |
| colOut | output | COL_W | Column of the current beat |
| colValid | output | 1 | A beat is being presented |
| lastBeat | output | 1 | Current beat is the last of a fixed-length burst |
| cfgErr | output | 1 | Last start asked for interleaved full page |

## Verification
Every result is registered, so a start sampled at one rising edge shows beat 0 after that edge, beat i shows i cycles later, and a stop or a final beat takes colValid low at the very next edge. The bench drives inputs on the falling edge and compares on the following falling edge, one clock after the stimulus, stepping one clock per expected beat. Expected columns come from a small model of the two orderings written in arithmetic form in the bench, and the full-page run crosses the wrap from the top column to 0 while watching that lastBeat never rises.

// File: rtl/colseq_pkg.sv
package colseq_pkg;

  // Strobes from the control to the datapath, valid in the current cycle.
  typedef struct packed {
    logic load;        // capture the new start column as beat 0
    logic step;        // advance to the column of beatNext
    logic clear;       // burst ends: drive the column to zero
    logic interleave;  // ordering of the running burst
  } seqStrobes_t;

  // Length codes; any code with bit 2 set selects full page.
  localparam logic [2:0] LEN_1 = 3'b000;
  localparam logic [2:0] LEN_2 = 3'b001;
  localparam logic [2:0] LEN_4 = 3'b010;
  localparam logic [2:0] LEN_8 = 3'b011;

endpackage

// File: rtl/burst_seq_ctrl.sv
module burst_seq_ctrl
  import colseq_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             stop,
  input  logic [2:0]       lenCode,
  input  logic             interleaveIn,
  output seqStrobes_t      strobes,
  output logic [COL_W-1:0] beatNext,
  output logic [COL_W-1:0] blMask,
  output logic             colValid,
  output logic             lastBeat,
  output logic             cfgErr
);

  localparam logic [COL_W-1:0] ALL_ONES = {COL_W{1'b1}};
  localparam logic [COL_W-1:0] ONE      = COL_W'(1);

  logic             activeQ;
  logic             pageQ;
  logic             ilvQ;
  logic             errQ;
  logic [COL_W-1:0] beatQ;
  logic [COL_W-1:0] maskQ;

  logic             reqPage;
  logic [COL_W-1:0] reqMask;
  logic             lastNow;
  logic             endNow;

  // Decode of the requested length into a low-bit mask.
  always_comb begin
    reqPage = lenCode[2];
    reqMask = reqPage ? ALL_ONES : ((ONE << lenCode[1:0]) - ONE);
  end

  always_comb begin
    lastNow            = activeQ && !pageQ && (beatQ == maskQ);
    endNow             = activeQ && !start && (stop || lastNow);
    strobes.load       = start;
    strobes.step       = activeQ && !start && !endNow;
    strobes.clear      = endNow;
    strobes.interleave = ilvQ;
    beatNext           = start ? '0 : beatQ + ONE;
    blMask             = maskQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      activeQ <= 1'b0;
      pageQ   <= 1'b0;
      ilvQ    <= 1'b0;
      errQ    <= 1'b0;
      beatQ   <= '0;
      maskQ   <= '0;
    end else if (start) begin
      activeQ <= 1'b1;
      beatQ   <= '0;
      pageQ   <= reqPage;
      maskQ   <= reqMask;
      ilvQ    <= interleaveIn && !reqPage;
      errQ    <= interleaveIn && reqPage;
    end else if (endNow) begin
      activeQ <= 1'b0;
      beatQ   <= '0;
    end else if (activeQ) begin
      beatQ   <= beatNext;
    end
  end

  assign colValid = activeQ;
  assign lastBeat = lastNow;
  assign cfgErr   = errQ;

  // R7: the final-beat flag only appears on a presented beat
  p_last_valid_r7: assert property (@(posedge clk) disable iff (!rstN)
    lastBeat |-> colValid);

  // R6: a full-page burst never flags a final beat
  p_page_nolast_r6: assert property (@(posedge clk) disable iff (!rstN)
    pageQ |-> !lastBeat);

  // R3: the burst ends right after its final beat unless restarted
  p_end_after_last_r3: assert property (@(posedge clk) disable iff (!rstN)
    lastBeat && !start |=> !colValid);

  // R8: a stop on a running burst ends it on the next cycle
  p_stop_ends_r8: assert property (@(posedge clk) disable iff (!rstN)
    colValid && stop && !start |=> !colValid);

  // R9: a start always yields a presented beat next cycle
  p_restart_r9: assert property (@(posedge clk) disable iff (!rstN)
    start |=> colValid && !$past(stop && !start));

  // R10: the error flag only accompanies a full-page burst
  p_err_page_r10: assert property (@(posedge clk) disable iff (!rstN)
    cfgErr |-> pageQ);

endmodule

// File: rtl/burst_seq_dp.sv
module burst_seq_dp
  import colseq_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqStrobes_t      strobes,
  input  logic [COL_W-1:0] startCol,
  input  logic [COL_W-1:0] beatNext,
  input  logic [COL_W-1:0] blMask,
  output logic [COL_W-1:0] colOut
);

  logic [COL_W-1:0] startQ;
  logic [COL_W-1:0] colQ;
  logic [COL_W-1:0] seqSum;
  logic [COL_W-1:0] nextCol;

  // Low bits of the sum equal (start + beat) modulo the burst length.
  assign seqSum = startQ + beatNext;

  // Per bit: bits under the mask follow the chosen ordering, the rest hold.
  for (genvar b = 0; b < COL_W; b++) begin : g_colBit
    always_comb begin
      if (!blMask[b])
        nextCol[b] = startQ[b];
      else if (strobes.interleave)
        nextCol[b] = startQ[b] ^ beatNext[b];
      else
        nextCol[b] = seqSum[b];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      startQ <= '0;
      colQ   <= '0;
    end else if (strobes.load) begin
      startQ <= startCol;
      colQ   <= startCol;
    end else if (strobes.clear) begin
      colQ   <= '0;
    end else if (strobes.step) begin
      colQ   <= nextCol;
    end
  end

  assign colOut = colQ;

  // R2: a load presents the start column on the next cycle
  p_load_col_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobes.load |=> colOut == $past(startCol));

  // R4: stepping never disturbs the bits above the burst block
  p_upper_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobes.step |=> (colOut & ~$past(blMask)) == ($past(startQ) & ~$past(blMask)));

  // R11: an ending burst leaves a zero column
  p_clear_zero_r11: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clear |=> colOut == '0);

endmodule

// File: rtl/sdram_col_seq.sv
module sdram_col_seq
  import colseq_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             stop,
  input  logic [COL_W-1:0] startCol,
  input  logic [2:0]       lenCode,
  input  logic             interleaveIn,
  output logic [COL_W-1:0] colOut,
  output logic             colValid,
  output logic             lastBeat,
  output logic             cfgErr
);

  seqStrobes_t      strobes;
  logic [COL_W-1:0] beatNext;
  logic [COL_W-1:0] blMask;

  burst_seq_ctrl #(.COL_W(COL_W)) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .start        (start),
    .stop         (stop),
    .lenCode      (lenCode),
    .interleaveIn (interleaveIn),
    .strobes      (strobes),
    .beatNext     (beatNext),
    .blMask       (blMask),
    .colValid     (colValid),
    .lastBeat     (lastBeat),
    .cfgErr       (cfgErr)
  );

  burst_seq_dp #(.COL_W(COL_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .startCol (startCol),
    .beatNext (beatNext),
    .blMask   (blMask),
    .colOut   (colOut)
  );

  // R11: no column is shown outside a burst
  p_idle_zero_r11: assert property (@(posedge clk) disable iff (!rstN)
    !colValid |-> colOut == '0);

endmodule

// File: tb/sdram_col_seq_tb.sv
`timescale 1ns/1ps
module sdram_col_seq_tb;

  localparam int COL_W = 9;
  localparam int PAGE  = 1 << COL_W;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             start = 1'b0;
  logic             stop = 1'b0;
  logic [COL_W-1:0] startCol = '0;
  logic [2:0]       lenCode = 3'b000;
  logic             interleaveIn = 1'b0;
  logic [COL_W-1:0] colOut;
  logic             colValid;
  logic             lastBeat;
  logic             cfgErr;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  sdram_col_seq #(.COL_W(COL_W)) u_dut (
    .clk(clk), .rstN(rstN), .start(start), .stop(stop), .startCol(startCol),
    .lenCode(lenCode), .interleaveIn(interleaveIn), .colOut(colOut),
    .colValid(colValid), .lastBeat(lastBeat), .cfgErr(cfgErr)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Model of the orderings, written from the requirements.
  function automatic int expCol(int s, int code, int ilv, int i);
    int bl;
    if (code >= 4) return (s + i) % PAGE;
    bl = 1 << code;
    if (ilv != 0) return s ^ i;
    return (s / bl) * bl + ((s % bl) + i) % bl;
  endfunction

  task automatic pulseStart(input int s, input int code, input int ilv);
    @(negedge clk);
    startCol = COL_W'(s); lenCode = 3'(code); interleaveIn = ilv[0]; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // Runs a fixed-length burst and checks every beat and the end.
  task automatic runFixed(input string req, input int s, input int code, input int ilv);
    int bl = 1 << code;
    pulseStart(s, code, ilv);
    for (int i = 0; i < bl; i++) begin
      chk(req, "column", colOut, expCol(s, code, ilv, i));
      chk("R2", "valid in burst", colValid, 1);
      chk("R7", "last flag", lastBeat, (i == bl - 1) ? 1 : 0);
      @(negedge clk);
    end
    chk("R3", "valid after end", colValid, 0);
    chk("R11", "idle column", colOut, 0);
  endtask

  task automatic testReset();
    chk("R1", "valid", colValid, 0);
    chk("R1", "last", lastBeat, 0);
    chk("R1", "column", colOut, 0);
    chk("R1", "cfgErr", cfgErr, 0);
  endtask

  task automatic testOrders();
    runFixed("R4", 9'h00A, 2, 0);
    runFixed("R5", 9'h01D, 3, 1);
    runFixed("R4", 9'h1FD, 3, 0);
    runFixed("R5", 9'h003, 1, 1);
    runFixed("R3", 9'h155, 0, 0);
    runFixed("R5", 9'h0F6, 2, 1);
  endtask

  task automatic testCfgLatched();
    pulseStart(9'h031, 2, 0);
    lenCode = 3'b111; interleaveIn = 1'b1;
    for (int i = 0; i < 4; i++) begin
      chk("R2", "column with inputs changed", colOut, expCol(9'h031, 2, 0, i));
      @(negedge clk);
    end
    chk("R2", "burst still 4 beats", colValid, 0);
    chk("R2", "cfgErr untouched", cfgErr, 0);
  endtask

  task automatic testFullPage();
    int s = 508;
    int seenLast = 0;
    pulseStart(s, 4, 0);
    for (int i = 0; i < PAGE + 6; i++) begin
      if (colOut != COL_W'(expCol(s, 4, 0, i)))
        chk("R6", "page column", colOut, expCol(s, 4, 0, i));
      if (lastBeat) seenLast++;
      @(negedge clk);
    end
    chk("R6", "page column after wrap", colOut, expCol(s, 4, 0, PAGE + 6));
    chk("R7", "no last in page", seenLast, 0);
    chk("R6", "still running", colValid, 1);
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
    chk("R8", "valid after stop", colValid, 0);
    chk("R11", "column after stop", colOut, 0);
  endtask

  task automatic testStop();
    pulseStart(9'h080, 3, 0);
    @(negedge clk);
    chk("R8", "beat 1", colOut, 9'h081);
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
    chk("R8", "stopped mid burst", colValid, 0);
    chk("R8", "no last after stop", lastBeat, 0);
    stop = 1'b1;
    @(negedge clk);
    @(negedge clk);
    stop = 1'b0;
    chk("R8", "stop while idle", colValid, 0);
    runFixed("R8", 9'h044, 1, 0);
  endtask

  task automatic testRestart();
    pulseStart(9'h040, 3, 0);
    @(negedge clk);
    @(negedge clk);
    chk("R9", "old burst beat 2", colOut, 9'h042);
    startCol = 9'h123; lenCode = 3'b010; interleaveIn = 1'b1; start = 1'b1; stop = 1'b1;
    @(negedge clk);
    start = 1'b0; stop = 1'b0;
    for (int i = 0; i < 4; i++) begin
      chk("R9", "new burst column", colOut, expCol(9'h123, 2, 1, i));
      chk("R9", "new burst valid", colValid, 1);
      chk("R9", "new burst last", lastBeat, (i == 3) ? 1 : 0);
      @(negedge clk);
    end
    chk("R9", "new burst ended", colValid, 0);
  endtask

  task automatic testIllegal();
    pulseStart(9'h1FE, 7, 1);
    chk("R10", "cfgErr set", cfgErr, 1);
    for (int i = 0; i < 5; i++) begin
      chk("R10", "sequential page order", colOut, expCol(9'h1FE, 4, 0, i));
      @(negedge clk);
    end
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
    chk("R10", "cfgErr held after stop", cfgErr, 1);
    pulseStart(9'h010, 1, 1);
    chk("R10", "cfgErr cleared by legal start", cfgErr, 0);
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testOrders();
    testCfgLatched();
    testStop();
    testRestart();
    testIllegal();
    testFullPage();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

endmodule